// File: doc/BRIEF.md
# CAN Node Operating-Mode and Interrupt Controller

This block is the register-mapped control core of a CAN node. Software writes 32-bit words at fixed offsets to enable the node, choose an operating mode, enable interrupts and clear interrupt flags. The block resolves these writes into exactly one active operating mode: configuration, normal, sleep, loopback or snoop. It drives that mode one-hot to the frame datapath and reports it in a status word that has a single bit set.

The datapath reports three kinds of event: a transmit request with the frame words to send, completion of a transmission on the bus, and a frame received from the bus. The block also sees a bus-activity indication. From these inputs it decides whether a transmission is launched on the bus, whether the frame is copied straight back into the receive registers (loopback), or whether the request is dropped. It also decides whether a bus frame is accepted and timestamped. It sets the transmit-OK and receive-OK flags and raises an interrupt line. A node in sleep mode wakes to normal mode by itself when the bus becomes active.

Top module: `can_mode_ctrl`

## Requirements
- R1: When bit 1 of the enable word (offset 0x00) is clear, the active mode is configuration and status (offset 0x18) reads 0x00000001. Setting that bit leaves configuration mode. Reading offset 0x00 returns only bit 1.
- R2: With the node enabled, the mode-select word (offset 0x04) chooses the active mode: 0 for normal, 1 for sleep, 2 for loopback and 4 for snoop.
- R3: Status has exactly one bit set: bit 0 for configuration, bit 3 for normal, bit 2 for sleep, bit 1 for loopback and bit 12 for snoop. The mode_oh output is one-hot: bit 0 configuration, bit 1 normal, bit 2 sleep, bit 3 loopback, bit 4 snoop.
- R4: The result is the same whether mode-select is written before the node is enabled or after it.
- R5: In sleep mode, a bus frame (rx_done) or bus_activity moves the active mode to normal on the next cycle. A frame that causes the wake is still stored and flags receive-OK. A new write to mode-select, or clearing enable, cancels the wake.
- R6: Interrupt status (offset 0x1C) holds transmit-OK in bit 1 and receive-OK in bit 4. Writing a 1 to a bit at offset 0x24 clears that flag. A flag set in the same cycle as its clear stays set.
- R7: In loopback mode, a tx_req copies the identifier, length word and both data words unchanged into the receive outputs on the next cycle. It sets both transmit-OK and receive-OK and does not start a bus transmission. Bus frames are ignored in loopback mode.
- R8: A bus frame accepted in normal, sleep or snoop mode is stored with a timestamp added to its length word. The timestamp is 1 for the first accepted bus frame after reset and increases by 1 with each further one.
- R9: In configuration mode, tx_req, tx_done and rx_done have no effect on the receive outputs, the flags or bus_tx_start.
- R10: In snoop mode, tx_req neither starts a bus transmission nor sets transmit-OK, but bus frames are accepted.
- R11: A mode-select value other than 0, 1, 2 or 4 selects normal mode, and offset 0x04 then reads 0.
- R12: The interrupt-enable word (offset 0x20) keeps only bits 1 and 4. irq is high exactly when a set flag is also enabled. Offsets with no register read 0.
- R13: In normal mode, tx_req pulses bus_tx_start on the next cycle, and tx_done sets transmit-OK. tx_req is ignored in sleep mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| tx_req | input | 1 | Transmit request for the frame on tx_* |
| tx_id | input | 32 | Frame identifier word to send |
| tx_len | input | 32 | Length-code word to send |
| tx_d0 | input | 32 | First data word to send |
| tx_d1 | input | 32 | Second data word to send |
| tx_done | input | 1 | Bus transmission completed |
| rx_done | input | 1 | Bus frame received on bus_* |
| bus_id | input | 32 | Received identifier word |
| bus_len | input | 32 | Received length-code word |
| bus_d0 | input | 32 | Received first data word |
| bus_d1 | input | 32 | Received second data word |
| bus_activity | input | 1 | Bus traffic seen |
| bus_tx_start | output | 1 | Launch a transmission on the bus |
| rx_id | output | 32 | Stored identifier word |
| rx_len | output | 32 | Stored length word (timestamped for bus frames) |
| rx_d0 | output | 32 | Stored first data word |
| rx_d1 | output | 32 | Stored second data word |
| mode_oh | output | 5 | One-hot active mode |
| irq | output | 1 | Interrupt request |

## Verification
A wrong active mode shows up at once in two places: in status and in mode_oh, whose one-hot bit order differs from the status bit order. It shows up again one cycle after a transmit request, when bus_tx_start, the flags or the receive outputs differ from what that mode allows. A wake flag that is left set or cleared wrongly is caught on the next status read after a re-selection of sleep. A stray timestamp count shows in the length word of the next accepted bus frame. Flag set/clear races are driven in the same cycle, so a reversed priority shows in the status read that follows.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

  typedef enum logic [4:0] {
    M_CFG   = 5'b00001,
    M_NORM  = 5'b00010,
    M_SLEEP = 5'b00100,
    M_LOOP  = 5'b01000,
    M_SNOOP = 5'b10000
  } mode_t;

  typedef struct packed {
    logic [31:0] id;
    logic [31:0] len;
    logic [31:0] d0;
    logic [31:0] d1;
  } frame_t;

  localparam logic [7:0] A_ENABLE  = 8'h00;
  localparam logic [7:0] A_MODESEL = 8'h04;
  localparam logic [7:0] A_STATUS  = 8'h18;
  localparam logic [7:0] A_ISR     = 8'h1C;
  localparam logic [7:0] A_IER     = 8'h20;
  localparam logic [7:0] A_ICR     = 8'h24;

  localparam int EN_BIT   = 1;
  localparam int TXOK_BIT = 1;
  localparam int RXOK_BIT = 4;
  localparam logic [31:0] FLAG_MASK = (32'd1 << TXOK_BIT) | (32'd1 << RXOK_BIT);

  // requested mode from a mode-select write; unknown codes fall back to normal
  function automatic mode_t sel_to_mode(input logic [31:0] v);
    case (v)
      32'd1:   return M_SLEEP;
      32'd2:   return M_LOOP;
      32'd4:   return M_SNOOP;
      default: return M_NORM;
    endcase
  endfunction

  function automatic logic [31:0] mode_to_sel(input mode_t m);
    case (m)
      M_SLEEP: return 32'd1;
      M_LOOP:  return 32'd2;
      M_SNOOP: return 32'd4;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] status_word(input mode_t m);
    logic [31:0] s;
    s = '0;
    case (m)
      M_CFG:   s[0]  = 1'b1;
      M_LOOP:  s[1]  = 1'b1;
      M_SLEEP: s[2]  = 1'b1;
      M_NORM:  s[3]  = 1'b1;
      M_SNOOP: s[12] = 1'b1;
      default: s = '0;
    endcase
    return s;
  endfunction

  function automatic logic [31:0] stamp_len(input logic [31:0] len, input logic [31:0] ts);
    return len + ts;
  endfunction

endpackage

// File: rtl/cmc_regs.sv
module cmc_regs
  import cmc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [31:0]       status_in,
  input  logic [31:0]       isr_in,
  output logic              en,
  output mode_t             req_mode,
  output logic              sel_wr,
  output logic [31:0]       ier,
  output logic [31:0]       clr_mask,
  output logic [31:0]       rdata
);

  logic hit_en, hit_sel, hit_ier, hit_icr;

  assign hit_en  = wr && (addr == ADDR_W'(A_ENABLE));
  assign hit_sel = wr && (addr == ADDR_W'(A_MODESEL));
  assign hit_ier = wr && (addr == ADDR_W'(A_IER));
  assign hit_icr = wr && (addr == ADDR_W'(A_ICR));

  assign sel_wr   = hit_sel;
  assign clr_mask = hit_icr ? (wdata & FLAG_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en       <= 1'b0;
      req_mode <= M_NORM;
      ier      <= '0;
    end else begin
      if (hit_en)  en       <= wdata[EN_BIT];
      if (hit_sel) req_mode <= sel_to_mode(wdata);
      if (hit_ier) ier      <= wdata & FLAG_MASK;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_ENABLE))       rdata[EN_BIT] = en;
    else if (addr == ADDR_W'(A_MODESEL)) rdata = mode_to_sel(req_mode);
    else if (addr == ADDR_W'(A_STATUS))  rdata = status_in;
    else if (addr == ADDR_W'(A_ISR))     rdata = isr_in;
    else if (addr == ADDR_W'(A_IER))     rdata = ier;
  end

endmodule

// File: rtl/cmc_mode.sv
module cmc_mode
  import cmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  mode_t req_mode,
  input  logic  sel_wr,
  input  logic  wake_evt,
  output mode_t cur_mode
);

  logic woke_q;

  always_comb begin
    if (!en)                                  cur_mode = M_CFG;
    else if (req_mode == M_SLEEP && woke_q)   cur_mode = M_NORM;
    else                                      cur_mode = req_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    woke_q <= 1'b0;
    else if (!en || sel_wr)                        woke_q <= 1'b0;
    else if (cur_mode == M_SLEEP && wake_evt)      woke_q <= 1'b1;
  end

endmodule

// File: rtl/cmc_frame.sv
module cmc_frame
  import cmc_pkg::*;
#(
  parameter int TS_W = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  mode_t  mode,
  input  logic   tx_req,
  input  frame_t tx_frm,
  input  logic   tx_done,
  input  logic   rx_done,
  input  frame_t bus_frm,
  output frame_t rx_frm,
  output logic   bus_tx_start,
  output logic   lb_fire,
  output logic   bus_accept,
  output logic   set_tx,
  output logic   set_rx
);

  logic [TS_W-1:0] ts_q;
  logic [TS_W-1:0] ts_next;
  logic            tx_launch;

  assign lb_fire    = tx_req && (mode == M_LOOP);
  assign tx_launch  = tx_req && (mode == M_NORM);
  assign bus_accept = rx_done &&
                      (mode == M_NORM || mode == M_SLEEP || mode == M_SNOOP);
  assign set_tx     = lb_fire || (tx_done && mode == M_NORM);
  assign set_rx     = lb_fire || bus_accept;
  assign ts_next    = ts_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q         <= '0;
      rx_frm       <= '0;
      bus_tx_start <= 1'b0;
    end else begin
      bus_tx_start <= tx_launch;
      if (lb_fire) begin
        rx_frm <= tx_frm;
      end else if (bus_accept) begin
        rx_frm.id  <= bus_frm.id;
        rx_frm.len <= stamp_len(bus_frm.len, 32'(ts_next));
        rx_frm.d0  <= bus_frm.d0;
        rx_frm.d1  <= bus_frm.d1;
        ts_q       <= ts_next;
      end
    end
  end

endmodule

// File: rtl/cmc_irq.sv
module cmc_irq
  import cmc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_tx,
  input  logic        set_rx,
  input  logic [31:0] clr_mask,
  input  logic [31:0] ier,
  output logic [31:0] isr,
  output logic        irq
);

  logic [31:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[TXOK_BIT] = set_tx;
    set_mask[RXOK_BIT] = set_rx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr <= '0;
    else        isr <= (set_mask | (isr & ~clr_mask)) & FLAG_MASK;
  end

  assign irq = |(isr & ier);

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import cmc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int TS_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tx_req,
  input  logic [31:0]       tx_id,
  input  logic [31:0]       tx_len,
  input  logic [31:0]       tx_d0,
  input  logic [31:0]       tx_d1,
  input  logic              tx_done,
  input  logic              rx_done,
  input  logic [31:0]       bus_id,
  input  logic [31:0]       bus_len,
  input  logic [31:0]       bus_d0,
  input  logic [31:0]       bus_d1,
  input  logic              bus_activity,
  output logic              bus_tx_start,
  output logic [31:0]       rx_id,
  output logic [31:0]       rx_len,
  output logic [31:0]       rx_d0,
  output logic [31:0]       rx_d1,
  output logic [4:0]        mode_oh,
  output logic              irq
);

  logic        en_w, sel_wr_w, lb_fire_w, bus_accept_w, set_tx_w, set_rx_w;
  mode_t       req_mode_w, cur_mode_w;
  logic [31:0] ier_w, clr_w, isr_w, status_w;
  frame_t      tx_frm_w, bus_frm_w, rx_frm_w;

  assign tx_frm_w  = '{id: tx_id, len: tx_len, d0: tx_d0, d1: tx_d1};
  assign bus_frm_w = '{id: bus_id, len: bus_len, d0: bus_d0, d1: bus_d1};
  assign status_w  = status_word(cur_mode_w);

  cmc_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .status_in(status_w), .isr_in(isr_w), .en(en_w), .req_mode(req_mode_w),
    .sel_wr(sel_wr_w), .ier(ier_w), .clr_mask(clr_w), .rdata(reg_rdata)
  );

  cmc_mode u_mode (
    .clk(clk), .rst_n(rst_n), .en(en_w), .req_mode(req_mode_w),
    .sel_wr(sel_wr_w), .wake_evt(bus_activity | rx_done), .cur_mode(cur_mode_w)
  );

  cmc_frame #(.TS_W(TS_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .mode(cur_mode_w), .tx_req(tx_req),
    .tx_frm(tx_frm_w), .tx_done(tx_done), .rx_done(rx_done),
    .bus_frm(bus_frm_w), .rx_frm(rx_frm_w), .bus_tx_start(bus_tx_start),
    .lb_fire(lb_fire_w), .bus_accept(bus_accept_w),
    .set_tx(set_tx_w), .set_rx(set_rx_w)
  );

  cmc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_tx(set_tx_w), .set_rx(set_rx_w),
    .clr_mask(clr_w), .ier(ier_w), .isr(isr_w), .irq(irq)
  );

  assign rx_id   = rx_frm_w.id;
  assign rx_len  = rx_frm_w.len;
  assign rx_d0   = rx_frm_w.d0;
  assign rx_d1   = rx_frm_w.d1;
  assign mode_oh = cur_mode_w;

endmodule

// File: rtl/cmc_checker.sv
module cmc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [4:0]  mode_oh,
  input logic        tx_req,
  input logic        rx_done,
  input logic        reg_wr,
  input logic        bus_tx_start,
  input logic        lb_fire,
  input logic [31:0] tx_id,
  input logic [31:0] rx_id,
  input logic [31:0] isr,
  input logic [31:0] clr,
  input logic        set_tx,
  input logic        irq
);

  p_mode_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1);

  p_cfg_no_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[0] && tx_req) |=> !bus_tx_start);

  p_snoop_no_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[4] && tx_req) |=> !bus_tx_start);

  p_norm_launch_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[1] && tx_req) |=> bus_tx_start);

  p_txok_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr[1] && !set_tx) |=> !isr[1]);

  p_loop_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lb_fire |=> (rx_id == $past(tx_id) && isr[1] && isr[4]));

  p_sleep_wake_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh[2] && rx_done && !reg_wr) |=> (mode_oh[1] && isr[4]));

  p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (isr != 32'd0));

endmodule

bind can_mode_ctrl cmc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode_oh(mode_oh), .tx_req(tx_req),
  .rx_done(rx_done), .reg_wr(reg_wr), .bus_tx_start(bus_tx_start),
  .lb_fire(lb_fire_w), .tx_id(tx_id), .rx_id(rx_id), .isr(isr_w),
  .clr(clr_w), .set_tx(set_tx_w), .irq(irq)
);

// File: tb/test_can_mode_ctrl.sv
`timescale 1ns/1ps
module test_can_mode_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_req = 1'b0, tx_done = 1'b0, rx_done = 1'b0, bus_activity = 1'b0;
  logic [31:0] tx_id = '0, tx_len = '0, tx_d0 = '0, tx_d1 = '0;
  logic [31:0] bus_id = '0, bus_len = '0, bus_d0 = '0, bus_d1 = '0;
  logic        bus_tx_start, irq;
  logic [31:0] rx_id, rx_len, rx_d0, rx_d1;
  logic [4:0]  mode_oh;

  int tests = 0;
  int fails = 0;
  int stamp = 0;
  logic [31:0] v;

  always #2.5 clk = ~clk;

  can_mode_ctrl i_can_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_req(tx_req),
    .tx_id(tx_id), .tx_len(tx_len), .tx_d0(tx_d0), .tx_d1(tx_d1),
    .tx_done(tx_done), .rx_done(rx_done), .bus_id(bus_id), .bus_len(bus_len),
    .bus_d0(bus_d0), .bus_d1(bus_d1), .bus_activity(bus_activity),
    .bus_tx_start(bus_tx_start), .rx_id(rx_id), .rx_len(rx_len),
    .rx_d0(rx_d0), .rx_d1(rx_d1), .mode_oh(mode_oh), .irq(irq)
  );

  // {select value, expected status, expected select readback, expected mode_oh}
  localparam logic [100:0] SEL_TAB [0:5] = '{
    {32'd0, 32'h0000_0008, 32'd0, 5'b00010},
    {32'd1, 32'h0000_0004, 32'd1, 5'b00100},
    {32'd2, 32'h0000_0002, 32'd2, 5'b01000},
    {32'd4, 32'h0000_1000, 32'd4, 5'b10000},
    {32'd3, 32'h0000_0008, 32'd0, 5'b00010},
    {32'd9, 32'h0000_0008, 32'd0, 5'b00010}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic set_mode(input logic [31:0] sel);
    wr(8'h00, 32'h0);
    wr(8'h04, sel);
    wr(8'h00, 32'h2);
  endtask

  task automatic send(input logic [31:0] id, input logic [31:0] len,
                      input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    tx_req = 1'b1; tx_id = id; tx_len = len; tx_d0 = a; tx_d1 = b;
    @(negedge clk);
    tx_req = 1'b0;
  endtask

  task automatic bus_frame(input logic [31:0] id, input logic [31:0] len,
                           input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    rx_done = 1'b1; bus_id = id; bus_len = len; bus_d0 = a; bus_d1 = b;
    @(negedge clk);
    rx_done = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(8'h18, v); chk("R1 reset status", v, 32'h1);
    chk("R3 reset mode_oh", 32'(mode_oh), 32'h1);
    chk("R12 reset irq", 32'(irq), 32'h0);
    chk("R7 reset rx_id", rx_id, 32'h0);

    // table of mode selections
    for (int i = 0; i < 6; i++) begin
      wr(8'h00, 32'h0);
      rd(8'h18, v); chk("R1 config status", v, 32'h1);
      wr(8'h04, SEL_TAB[i][100:69]);
      wr(8'h00, 32'h2);
      rd(8'h18, v); chk("R2/R3 status", v, SEL_TAB[i][68:37]);
      rd(8'h04, v); chk("R11 select readback", v, SEL_TAB[i][36:5]);
      chk("R3 mode_oh", 32'(mode_oh), 32'(SEL_TAB[i][4:0]));
    end

    // R4: select written after enable
    wr(8'h00, 32'h0);
    wr(8'h00, 32'h2);
    wr(8'h04, 32'h2);
    rd(8'h18, v); chk("R4 select after enable", v, 32'h2);

    // R7: loopback copies frame unchanged
    send(32'hFF, 32'h8000_0000, 32'h1234_5678, 32'h8765_4321);
    chk("R7 no bus launch", 32'(bus_tx_start), 32'h0);
    chk("R7 rx_id", rx_id, 32'hFF);
    chk("R7 rx_len", rx_len, 32'h8000_0000);
    chk("R7 rx_d0", rx_d0, 32'h1234_5678);
    chk("R7 rx_d1", rx_d1, 32'h8765_4321);
    rd(8'h1C, v); chk("R7 flags", v, 32'h12);
    bus_frame(32'h55, 32'h1, 32'h2, 32'h3);
    chk("R7 bus frame ignored", rx_id, 32'hFF);

    // R6: clear by write-one
    wr(8'h24, 32'h10);
    rd(8'h1C, v); chk("R6 clear rxok only", v, 32'h2);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h1C, v); chk("R6 clear all", v, 32'h0);

    // R13 / R8: normal mode
    set_mode(32'h0);
    send(32'h14, 32'h8000_0000, 32'h1, 32'h2);
    chk("R13 bus launch", 32'(bus_tx_start), 32'h1);
    rd(8'h1C, v); chk("R13 no txok before done", v, 32'h0);
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    rd(8'h1C, v); chk("R13 txok on done", v, 32'h2);
    wr(8'h24, 32'h12);
    bus_frame(32'h14, 32'h8000_0000, 32'h1234_5678, 32'h8765_4321);
    stamp++;
    chk("R8 first stamp", rx_len, 32'h8000_0000 + 32'(stamp));
    chk("R8 id", rx_id, 32'h14);
    bus_frame(32'h15, 32'h0000_0004, 32'h0, 32'h0);
    stamp++;
    chk("R8 second stamp", rx_len, 32'h4 + 32'(stamp));
    wr(8'h24, 32'h12);

    // R5: sleep wake on a frame
    set_mode(32'h1);
    rd(8'h18, v); chk("R5 sleeping", v, 32'h4);
    send(32'h77, 32'h0, 32'h0, 32'h0);
    chk("R13 sleep tx ignored", 32'(bus_tx_start), 32'h0);
    bus_frame(32'h21, 32'h8000_0000, 32'hA, 32'hB);
    stamp++;
    rd(8'h18, v); chk("R5 woke to normal", v, 32'h8);
    chk("R5 wake frame stored", rx_len, 32'h8000_0000 + 32'(stamp));
    rd(8'h1C, v); chk("R5 rxok on wake", v, 32'h10);
    wr(8'h04, 32'h1);
    rd(8'h18, v); chk("R5 reselect sleep", v, 32'h4);
    @(negedge clk); bus_activity = 1'b1; @(negedge clk); bus_activity = 1'b0;
    rd(8'h18, v); chk("R5 wake on activity", v, 32'h8);
    wr(8'h24, 32'h12);

    // R10: snoop
    set_mode(32'h4);
    send(32'h33, 32'h0, 32'h0, 32'h0);
    chk("R10 no bus launch", 32'(bus_tx_start), 32'h0);
    rd(8'h1C, v); chk("R10 no txok", v, 32'h0);
    bus_frame(32'h44, 32'h8, 32'h1, 32'h1);
    stamp++;
    chk("R10 frame accepted", rx_len, 32'h8 + 32'(stamp));
    wr(8'h24, 32'h12);

    // R9: configuration mode ignores events
    wr(8'h00, 32'h0);
    bus_frame(32'h99, 32'h9, 32'h9, 32'h9);
    chk("R9 rx ignored", rx_id, 32'h44);
    send(32'h98, 32'h0, 32'h0, 32'h0);
    chk("R9 no launch", 32'(bus_tx_start), 32'h0);
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    rd(8'h1C, v); chk("R9 no flags", v, 32'h0);

    // R12: interrupt enable and unused bits
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R12 ier bits", v, 32'h12);
    set_mode(32'h2);
    chk("R12 irq idle", 32'(irq), 32'h0);
    send(32'h1, 32'h2, 32'h3, 32'h4);
    chk("R12 irq raised", 32'(irq), 32'h1);
    wr(8'h20, 32'h0);
    chk("R12 irq masked", 32'(irq), 32'h0);
    rd(8'h08, v); chk("R12 unmapped offset", v, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R1 enable readback", v, 32'h2);

    // R6: set beats clear in the same cycle
    wr(8'h24, 32'h12);
    @(negedge clk);
    tx_req = 1'b1; reg_wr = 1'b1; reg_addr = 8'h24; reg_wdata = 32'h12;
    @(negedge clk);
    tx_req = 1'b0; reg_wr = 1'b0;
    rd(8'h1C, v); chk("R6 set wins over clear", v, 32'h12);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule